// File: doc/BRIEF.md
# Random generator register controller

This block is a memory-mapped front end for a stand-alone random number generator. Software drives it through a small 32-bit register bus. It writes a command to start a seed or a generate run, polls a status word, and reads up to eight 32-bit result words once a ready flag appears in the interrupt status register. The ready flag stays set until software writes a one back to that bit. An enable register gates the ready and seed-done flags onto a level interrupt output.

The noise source is replaced by a deterministic 64-bit LFSR that advances on every clock. Seed and generate runs last a fixed, parameterised number of cycles, so every output word can be predicted. The block seeds itself after reset. A programmable threshold, counted in 16-byte units of delivered output, makes it insert a reseed ahead of a generate request.

Top module: `rng_ctrl`

## Requirements
- R1: The command register is at byte offset 0x00. Writing 1 starts a generate run and writing 2 starts a seed run. Any other written value has no effect, and the register reads as zero.
- R2: The status register is at byte offset 0x04. Bit 9 is "seeded", bit 30 is "generate busy" and bit 31 is "seed busy". Bits 30 and 31 are never both set, and every other bit reads zero.
- R3: After reset the block runs a seed on its own. Status reads 0x8000_0000 for SEED_CYCLES cycles, then 0x0000_0200. Every seed completion sets interrupt status bit 1. A seed run started by command clears bit 9 until that run completes.
- R4: A generate run keeps status bit 30 set for GEN_CYCLES cycles. On its last cycle it updates the output words and sets interrupt status bit 0.
- R5: The interrupt status register is at byte offset 0x14 and holds bit 0 (ready) and bit 1 (seed done). Writing a one to a bit clears it. A flag being set in the same cycle as a clear stays set.
- R6: Output word i is readable at byte offset 0x20+4*i, for i from 0 to 7. Let v be the LFSR value in the completing cycle, XORed with the key captured at the last seed completion. Word i is the low half of v when i is even and the high half when i is odd, XORed with 0x9E3779B9*(i+1) modulo 2^32. The words hold their values until the next generate run completes.
- R7: The mode register is at byte offset 0x08, and only bit 3 is stored (1 selects 256-bit output, 0 selects 128-bit output). The mode is sampled when a generate command is accepted. A 128-bit run writes zero to words 4 to 7.
- R8: A command written while a seed or generate run is in progress is ignored, and the run in progress continues unchanged.
- R9: The reseed threshold register is at byte offset 0x60, is CNT_W bits wide and resets to 0, which disables the feature. Completed runs add 1 (128-bit) or 2 (256-bit) to a served count, which saturates at its maximum and returns to 0 on every seed completion. When a generate command is accepted with a nonzero threshold and a served count at or above it, a full seed run executes first and is followed directly by the generate run.
- R10: The LFSR resets to LFSR_INIT and advances every clock by shifting left one place. The new bit 0 is the XOR of bits 63, 62, 60 and 59.
- R11: The interrupt enable register is at byte offset 0x10, and only bits 31, 1 and 0 are stored. The output irq_o equals bit 31 AND ((bit 0 AND ready flag) OR (bit 1 AND seed-done flag)).
- R12: Byte offset 0xF0 reads the constant 0x0000_46BC. Every other unmapped offset reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | ADDR_W | Byte address of the register access |
| bus_we_i | input | 1 | Write strobe, one cycle per write |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest case to reach from the ports is a write-one-to-clear of the ready flag that lands in the same cycle as a generate completion. The bench reaches it by counting GEN_CYCLES cycles from the accepted command and placing the clear write on the completion edge. A second hard case is the served count reaching the reseed threshold through a mix of 256-bit and 128-bit runs. The bench reaches it by programming a threshold of 3, restarting the count with a manual seed, and then issuing one wide run, one narrow run and a final request that must first be turned into a seed run. A behavioural model predicts status, words, flags and interrupt on every clock, so commands dropped while busy are seen directly in the status and word sequence.

// File: rtl/rng_pkg.sv
`timescale 1ns/1ps
package rng_pkg;
    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 8;
    localparam int ENT_W     = 2 * WORD_W;

    // word offsets (byte offset / 4)
    localparam int OFS_CMD    = 'h00;
    localparam int OFS_STAT   = 'h01;
    localparam int OFS_MODE   = 'h02;
    localparam int OFS_IEN    = 'h04;
    localparam int OFS_ISTAT  = 'h05;
    localparam int OFS_WORD0  = 'h08;
    localparam int OFS_RESEED = 'h18;
    localparam int OFS_VER    = 'h3C;

    localparam logic [WORD_W-1:0] CMD_GEN    = 32'd1;
    localparam logic [WORD_W-1:0] CMD_SEED   = 32'd2;
    localparam logic [WORD_W-1:0] VERSION_ID = 32'h0000_46BC;
    localparam logic [WORD_W-1:0] MIX_STEP   = 32'h9E37_79B9;
    localparam logic [WORD_W-1:0] IEN_MASK   = 32'h8000_0003;
    localparam logic [ENT_W-1:0]  LFSR_TAPS  = 64'hD800_0000_0000_0000;

    localparam int ST_SEEDED_BIT = 9;
    localparam int ST_GEN_BIT    = 30;
    localparam int ST_SEED_BIT   = 31;
    localparam int MODE_BIT      = 3;
    localparam int IE_GLOBAL     = 31;
    localparam int IS_RDY        = 0;
    localparam int IS_SEED       = 1;
    localparam int IS_W          = 2;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_SEED = 2'd1,
        SQ_GEN  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/rng_lfsr.sv
`timescale 1ns/1ps
module rng_lfsr
    import rng_pkg::*;
#(
    parameter logic [ENT_W-1:0] INIT = 64'h0123_4567_89AB_CDEF
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [ENT_W-1:0] state_o
);
    logic [ENT_W-1:0] lfsr_d, lfsr_q;

    always_comb begin
        lfsr_d = {lfsr_q[ENT_W-2:0], ^(lfsr_q & LFSR_TAPS)};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lfsr_q <= INIT;
        else        lfsr_q <= lfsr_d;
    end

    assign state_o = lfsr_q;

    // R10: never locks up in the all-zero state
    a_r10_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);
endmodule

// File: rtl/rng_sequencer.sv
`timescale 1ns/1ps
module rng_sequencer
    import rng_pkg::*;
#(
    parameter int SEED_CYCLES = 12,
    parameter int GEN_CYCLES  = 6,
    parameter int CNT_W       = 16
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cmd_gen_i,
    input  logic                              cmd_seed_i,
    input  logic                              wide_i,
    input  logic [CNT_W-1:0]                  limit_i,
    input  logic [ENT_W-1:0]                  entropy_i,
    output seq_state_e                        state_o,
    output logic                              seeded_o,
    output logic                              gen_done_o,
    output logic                              seed_done_o,
    output logic [NUM_WORDS-1:0][WORD_W-1:0]  words_o
);
    localparam int MAX_CYC = (SEED_CYCLES > GEN_CYCLES) ? SEED_CYCLES : GEN_CYCLES;
    localparam int CYC_W   = $clog2(MAX_CYC + 1);
    localparam int HALF    = NUM_WORDS / 2;

    typedef struct packed {
        seq_state_e                       state;
        logic [CYC_W-1:0]                 cnt;
        logic                             seeded;
        logic                             after;
        logic                             wide;
        logic [ENT_W-1:0]                 key;
        logic [CNT_W-1:0]                 served;
        logic [NUM_WORDS-1:0][WORD_W-1:0] words;
    } seq_regs_t;

    localparam seq_regs_t SEQ_RST = '{
        state:  SQ_SEED,
        cnt:    '0,
        seeded: 1'b0,
        after:  1'b0,
        wide:   1'b0,
        key:    '0,
        served: '0,
        words:  '0
    };

    seq_regs_t q, d;

    logic [ENT_W-1:0]                 mixed;
    logic [NUM_WORDS-1:0][WORD_W-1:0] fresh;
    logic [CNT_W:0]                   served_sum;
    logic                             over_limit;

    assign mixed = entropy_i ^ q.key;

    for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_mix
        localparam logic [WORD_W-1:0] K = WORD_W'(MIX_STEP * WORD_W'(gi + 1));
        if (gi % 2 == 0) begin : g_lo
            assign fresh[gi] = mixed[WORD_W-1:0] ^ K;
        end else begin : g_hi
            assign fresh[gi] = mixed[ENT_W-1:WORD_W] ^ K;
        end
    end

    always_comb begin
        d           = q;
        gen_done_o  = (q.state == SQ_GEN)  && (q.cnt == CYC_W'(GEN_CYCLES - 1));
        seed_done_o = (q.state == SQ_SEED) && (q.cnt == CYC_W'(SEED_CYCLES - 1));
        served_sum  = {1'b0, q.served} + (q.wide ? (CNT_W+1)'(2) : (CNT_W+1)'(1));
        over_limit  = (limit_i != '0) && (q.served >= limit_i);

        unique case (q.state)
            SQ_IDLE: begin
                if (cmd_gen_i) begin
                    d.wide = wide_i;
                    d.cnt  = '0;
                    if (over_limit) begin
                        d.state  = SQ_SEED;
                        d.seeded = 1'b0;
                        d.after  = 1'b1;
                    end else begin
                        d.state = SQ_GEN;
                    end
                end else if (cmd_seed_i) begin
                    d.state  = SQ_SEED;
                    d.cnt    = '0;
                    d.seeded = 1'b0;
                    d.after  = 1'b0;
                end
            end
            SQ_SEED: begin
                if (seed_done_o) begin
                    d.seeded = 1'b1;
                    d.key    = entropy_i;
                    d.served = '0;
                    d.cnt    = '0;
                    d.state  = q.after ? SQ_GEN : SQ_IDLE;
                    d.after  = 1'b0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            SQ_GEN: begin
                if (gen_done_o) begin
                    for (int i = 0; i < NUM_WORDS; i++) begin
                        d.words[i] = (i >= HALF && !q.wide) ? '0 : fresh[i];
                    end
                    d.served = served_sum[CNT_W] ? '1 : served_sum[CNT_W-1:0];
                    d.state  = SQ_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign state_o  = q.state;
    assign seeded_o = q.seeded;
    assign words_o  = q.words;

    // R6: words change only on a generate completion
    a_r6_words_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_done_o |=> $stable(words_o));
    // R7: narrow runs leave the upper words zero
    a_r7_narrow_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_done_o && !q.wide) |=> (words_o[NUM_WORDS-1:HALF] == '0));
    // R9: a request at the threshold turns into a seed run first
    a_r9_reseed_first: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == SQ_IDLE && cmd_gen_i && over_limit) |=> (state_o == SQ_SEED));
    // R8: a running sequence is not disturbed before its end
    a_r8_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state != SQ_IDLE && !gen_done_o && !seed_done_o) |=> $stable(state_o));
    // R3: a completed seed leaves the seeded flag set
    a_r3_seeded_after: assert property (@(posedge clk) disable iff (!rst_n)
        seed_done_o |=> seeded_o);
endmodule

// File: rtl/rng_ctrl.sv
`timescale 1ns/1ps
module rng_ctrl
    import rng_pkg::*;
#(
    parameter int               ADDR_W      = 8,
    parameter int               SEED_CYCLES = 12,
    parameter int               GEN_CYCLES  = 6,
    parameter int               CNT_W       = 16,
    parameter logic [ENT_W-1:0] LFSR_INIT   = 64'h0123_4567_89AB_CDEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              irq_o
);
    localparam int WSEL_W = $clog2(NUM_WORDS);

    typedef struct packed {
        logic [WORD_W-1:0] ien;
        logic              wide;
        logic [CNT_W-1:0]  limit;
        logic [IS_W-1:0]   istat;
    } ctl_regs_t;

    ctl_regs_t q, d;

    int                               wa;
    logic                             cmd_gen, cmd_seed;
    logic [ENT_W-1:0]                 entropy;
    seq_state_e                       seq_state;
    logic                             seeded, gen_done, seed_done;
    logic [NUM_WORDS-1:0][WORD_W-1:0] words;
    logic [WORD_W-1:0]                status_w;
    logic [IS_W-1:0]                  clr_bits, set_bits;
    logic                             unused_addr;

    assign unused_addr = ^bus_addr_i[1:0];

    always_comb begin
        wa = int'(bus_addr_i[ADDR_W-1:2]);
    end

    assign cmd_gen  = bus_we_i && (wa == OFS_CMD) && (bus_wdata_i == CMD_GEN);
    assign cmd_seed = bus_we_i && (wa == OFS_CMD) && (bus_wdata_i == CMD_SEED);

    rng_lfsr #(
        .INIT (LFSR_INIT)
    ) u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_o (entropy)
    );

    rng_sequencer #(
        .SEED_CYCLES (SEED_CYCLES),
        .GEN_CYCLES  (GEN_CYCLES),
        .CNT_W       (CNT_W)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_gen_i   (cmd_gen),
        .cmd_seed_i  (cmd_seed),
        .wide_i      (q.wide),
        .limit_i     (q.limit),
        .entropy_i   (entropy),
        .state_o     (seq_state),
        .seeded_o    (seeded),
        .gen_done_o  (gen_done),
        .seed_done_o (seed_done),
        .words_o     (words)
    );

    always_comb begin
        status_w                = '0;
        status_w[ST_SEEDED_BIT] = seeded;
        status_w[ST_GEN_BIT]    = (seq_state == SQ_GEN);
        status_w[ST_SEED_BIT]   = (seq_state == SQ_SEED);
    end

    always_comb begin
        d                 = q;
        set_bits          = '0;
        set_bits[IS_RDY]  = gen_done;
        set_bits[IS_SEED] = seed_done;
        clr_bits          = (bus_we_i && wa == OFS_ISTAT) ? bus_wdata_i[IS_W-1:0] : '0;
        d.istat           = (q.istat & ~clr_bits) | set_bits;
        if (bus_we_i) begin
            if (wa == OFS_IEN)    d.ien   = bus_wdata_i & IEN_MASK;
            if (wa == OFS_MODE)   d.wide  = bus_wdata_i[MODE_BIT];
            if (wa == OFS_RESEED) d.limit = bus_wdata_i[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        bus_rdata_o = '0;
        if (wa >= OFS_WORD0 && wa < OFS_WORD0 + NUM_WORDS) begin
            bus_rdata_o = words[WSEL_W'(wa - OFS_WORD0)];
        end else begin
            case (wa)
                OFS_STAT:   bus_rdata_o = status_w;
                OFS_MODE:   bus_rdata_o[MODE_BIT] = q.wide;
                OFS_IEN:    bus_rdata_o = q.ien;
                OFS_ISTAT:  bus_rdata_o[IS_W-1:0] = q.istat;
                OFS_RESEED: bus_rdata_o[CNT_W-1:0] = q.limit;
                OFS_VER:    bus_rdata_o = VERSION_ID;
                default:    bus_rdata_o = '0;
            endcase
        end
    end

    assign irq_o = q.ien[IE_GLOBAL] &&
                   ((q.ien[IS_RDY] && q.istat[IS_RDY]) || (q.ien[IS_SEED] && q.istat[IS_SEED]));

    // R4 / R5: a completed generate run is visible as the ready flag
    a_r5_rdy_set: assert property (@(posedge clk) disable iff (!rst_n)
        gen_done |=> q.istat[IS_RDY]);
    // R2: the two busy bits are exclusive
    a_r2_busy_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(status_w[ST_GEN_BIT] && status_w[ST_SEED_BIT]));
    // R11: no interrupt without the global enable
    a_r11_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        !q.ien[IE_GLOBAL] |-> !irq_o);
    // R3: a seed completion raises the seed-done flag
    a_r3_seed_flag: assert property (@(posedge clk) disable iff (!rst_n)
        seed_done |=> q.istat[IS_SEED]);
endmodule

// File: tb/rng_ctrl_test.sv
`timescale 1ns/1ps
module rng_ctrl_test;
    localparam int SEED_CYC = 12;
    localparam int GEN_CYC  = 6;
    localparam int CNT_W    = 16;
    localparam logic [63:0] INIT = 64'h0123_4567_89AB_CDEF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  b_addr = 8'h04;
    logic        b_we = 1'b0;
    logic [31:0] b_wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    rng_ctrl #(
        .ADDR_W      (8),
        .SEED_CYCLES (SEED_CYC),
        .GEN_CYCLES  (GEN_CYC),
        .CNT_W       (CNT_W),
        .LFSR_INIT   (INIT)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr_i  (b_addr),
        .bus_we_i    (b_we),
        .bus_wdata_i (b_wdata),
        .bus_rdata_o (rdata),
        .irq_o       (irq)
    );

    // behavioural reference model: 0 idle, 1 seeding, 2 generating
    int          m_state = 1;
    int          m_cnt = 0;
    bit          m_seeded = 0, m_after = 0, m_wide = 0, m_mode = 0;
    logic [63:0] m_lfsr = INIT, m_key = '0;
    logic [31:0] m_words [8];
    logic [31:0] m_ie = '0;
    logic [1:0]  m_istat = '0;
    int          m_limit = 0, m_served = 0;

    task automatic model_reset();
        m_state = 1; m_cnt = 0; m_seeded = 0; m_after = 0; m_wide = 0; m_mode = 0;
        m_lfsr = INIT; m_key = '0; m_ie = '0; m_istat = '0; m_limit = 0; m_served = 0;
        for (int i = 0; i < 8; i++) m_words[i] = '0;
    endtask

    task automatic model_step();
        logic [63:0] v;
        logic [1:0]  set_b, clr;
        bit          fb;
        bit          wcmd;
        set_b = '0;
        wcmd  = b_we && (b_addr[7:2] == 6'h00);
        if (m_state == 0) begin
            if (wcmd && b_wdata == 1) begin
                m_wide = m_mode; m_cnt = 0;
                if (m_limit != 0 && m_served >= m_limit) begin
                    m_state = 1; m_seeded = 0; m_after = 1;
                end else m_state = 2;
            end else if (wcmd && b_wdata == 2) begin
                m_state = 1; m_cnt = 0; m_seeded = 0; m_after = 0;
            end
        end else if (m_state == 1) begin
            if (m_cnt == SEED_CYC - 1) begin
                m_seeded = 1; m_key = m_lfsr; m_served = 0; m_cnt = 0; set_b[1] = 1'b1;
                m_state = m_after ? 2 : 0; m_after = 0;
            end else m_cnt++;
        end else begin
            if (m_cnt == GEN_CYC - 1) begin
                v = m_lfsr ^ m_key;
                for (int i = 0; i < 8; i++) begin
                    if (i >= 4 && !m_wide) m_words[i] = '0;
                    else m_words[i] = ((i % 2 == 0) ? v[31:0] : v[63:32]) ^ 32'(32'h9E37_79B9 * 32'(i + 1));
                end
                m_served = m_served + (m_wide ? 2 : 1);
                if (m_served > (1 << CNT_W) - 1) m_served = (1 << CNT_W) - 1;
                set_b[0] = 1'b1; m_state = 0;
            end else m_cnt++;
        end
        clr = (b_we && b_addr[7:2] == 6'h05) ? b_wdata[1:0] : 2'b00;
        m_istat = (m_istat & ~clr) | set_b;
        if (b_we && b_addr[7:2] == 6'h04) m_ie = b_wdata & 32'h8000_0003;
        if (b_we && b_addr[7:2] == 6'h02) m_mode = b_wdata[3];
        if (b_we && b_addr[7:2] == 6'h18) m_limit = int'(b_wdata[CNT_W-1:0]);
        fb = m_lfsr[63] ^ m_lfsr[62] ^ m_lfsr[60] ^ m_lfsr[59];
        m_lfsr = {m_lfsr[62:0], fb};
    endtask

    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
    end

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        logic [31:0] r;
        r = '0;
        if (a[7:2] >= 6'h08 && a[7:2] <= 6'h0F) r = m_words[a[4:2]];
        else case (a[7:2])
            6'h01: begin r[31] = (m_state == 1); r[30] = (m_state == 2); r[9] = m_seeded; end
            6'h02: r[3] = m_mode;
            6'h04: r = m_ie;
            6'h05: r[1:0] = m_istat;
            6'h18: r = 32'(m_limit);
            6'h3C: r = 32'h0000_46BC;
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic string tag_of(logic [7:0] a);
        if (a[7:2] >= 6'h08 && a[7:2] <= 6'h0F) return "R6";
        case (a[7:2])
            6'h00: return "R1";
            6'h01: return "R2";
            6'h02: return "R7";
            6'h04: return "R11";
            6'h05: return "R5";
            6'h18: return "R9";
            default: return "R12";
        endcase
    endfunction

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s addr=%02h actual=%08h expected=%08h t=%0t", req, b_addr, act, exp, $time);
        end
    endtask

    // per-cycle comparison just before each rising edge
    always @(negedge clk) begin
        #2;
        check32(tag_of(b_addr), rdata, exp_rd(b_addr));
        check32("R11", {31'b0, irq},
                {31'b0, m_ie[31] & ((m_ie[0] & m_istat[0]) | (m_ie[1] & m_istat[1]))});
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected<=20000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] v);
        @(negedge clk);
        b_addr = a; b_we = 1'b1; b_wdata = v;
        @(negedge clk);
        b_we = 1'b0;
    endtask

    task automatic peek(logic [7:0] a);
        @(negedge clk);
        b_addr = a;
    endtask

    task automatic watch(int n);
        peek(8'h04);
        repeat (n) @(negedge clk);
    endtask

    task automatic read_words();
        for (int i = 0; i < 8; i++) peek(8'h20 + 8'(4 * i));
    endtask

    initial begin
        // reset state and R3 automatic seeding, R10 via words later
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        watch(SEED_CYC + 3);
        // R12 version and unmapped, R1 command reads zero
        peek(8'hF0); peek(8'h0C); peek(8'h44); peek(8'hFC); peek(8'h00); peek(8'h60);
        // R11 enable all, seed-done flag drives irq
        wr(8'h10, 32'hFFFF_FFFF); peek(8'h10);
        // R5 clear seed-done flag
        wr(8'h14, 32'h2); peek(8'h14);
        // R7 wide mode, R4 generate, R6 words
        wr(8'h08, 32'h8); peek(8'h08);
        wr(8'h00, 32'h1); watch(GEN_CYC + 2);
        read_words(); peek(8'h14);
        wr(8'h14, 32'h1); peek(8'h14);
        // R8 commands while busy are ignored
        wr(8'h00, 32'h1); wr(8'h00, 32'h2); wr(8'h00, 32'h1);
        watch(GEN_CYC + 2); read_words();
        wr(8'h00, 32'h2); wr(8'h00, 32'h1); watch(SEED_CYC + 2);
        // R5 clear colliding with completion: set wins
        wr(8'h00, 32'h1);
        repeat (GEN_CYC - 2) @(negedge clk);
        wr(8'h14, 32'h1); peek(8'h14); peek(8'h14);
        // R7 narrow mode zeroes words 4..7
        wr(8'h08, 32'h0); wr(8'h00, 32'h1); watch(GEN_CYC + 2); read_words();
        // R9 auto reseed after 3 units: wide(2) + narrow(1)
        wr(8'h60, 32'h3); peek(8'h60);
        wr(8'h00, 32'h2); watch(SEED_CYC + 2);
        wr(8'h08, 32'h8); wr(8'h00, 32'h1); watch(GEN_CYC + 2);
        wr(8'h08, 32'h0); wr(8'h00, 32'h1); watch(GEN_CYC + 2);
        wr(8'h00, 32'h1); watch(SEED_CYC + GEN_CYC + 4);
        read_words(); peek(8'h14);
        // R9 threshold 0 disables
        wr(8'h60, 32'h0);
        for (int k = 0; k < 3; k++) begin
            wr(8'h00, 32'h1); watch(GEN_CYC + 2);
        end
        // R1 other command values do nothing
        wr(8'h00, 32'h3); watch(3); wr(8'h00, 32'h0); watch(3);
        // R11 global enable off masks irq
        wr(8'h10, 32'h0000_0003); peek(8'h10); peek(8'h14);
        wr(8'h10, 32'h8000_0001); peek(8'h14);
        wr(8'h14, 32'h3); peek(8'h14);
        // R10 words after more LFSR steps
        wr(8'h08, 32'h8); wr(8'h00, 32'h1); watch(GEN_CYC + 2); read_words();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule